// File: doc/BRIEF.md
# NAND Bad-Block Scan Engine

This block builds a one-bit-per-block map of unusable erase blocks in a small NAND array. It leaves reset already scanning. For each block in turn it asks a lower-level flash access layer for the marker byte at a fixed spare column (517) of the block's first page. If that byte is the erased value FFh it then reads the same column of the second page. A block is flagged when either byte differs from FFh. When the first page already shows a marker, the second read is skipped.

The read side is a request/response pair. The engine holds `rd_req` high with a stable block, page and column until the access layer returns `rd_valid` with the byte. After the last block the engine raises `done`, stops requesting and presents the number of flagged blocks. A registered lookup port reports the flag of any block. Lookups made before the scan completes come back as "unknown" while `busy` is high. The surrounding system can flag further blocks, for example after a failed erase or program, through a mark port. A `start` pulse wipes the map and walks the array again from block 0.

Top module: `nand_bbscan`

## Requirements
- R1: After reset the engine requests immediately: `rd_req`=1, block 0, page 0, column `MARK_COL` (517). `done`=0, `busy`=1 and `bad_count`=0.
- R2: Every request uses column `MARK_COL` and page 0 or 1 of the block. The block and page hold steady until a byte is accepted. A byte is accepted only on a cycle where both `rd_req` and `rd_valid` are high.
- R3: An accepted byte other than FFh flags the current block. A page-0 byte equal to FFh leads to a page-1 request of the same block. A page-0 byte other than FFh skips page 1 and moves straight to page 0 of the next block.
- R4: After an accepted page-1 byte the engine moves to page 0 of the next block. After the last block it raises `done` and lowers `rd_req` in the following cycle.
- R5: While `done` is high, `bad_count` equals the number of flagged blocks. While the scan runs, `bad_count` reads 0.
- R6: A `start` pulse clears every flag and the count. In the next cycle the engine requests block 0 page 0 with `done` low. A byte accepted in the same cycle as `start` is discarded.
- R7: A cycle with `lk_req` high produces `lk_ack`=1 one cycle later. When `done` was high in the request cycle, `lk_bad` carries the flag of `lk_block` and `lk_unknown`=0. All three outputs are 0 on cycles that follow no request.
- R8: A lookup requested while `done` is low returns `lk_unknown`=1 and `lk_bad`=0.
- R9: `mark_req` flags `mark_block` at any time, including during a scan. A block adds to the count only once. Marking an already flagged block leaves the count unchanged. A mark in the same cycle as `start` is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Clear the map and rescan from block 0 |
| rd_req | output | 1 | Read request to the flash access layer |
| rd_block | output | BLK_W | Block address of the request |
| rd_page | output | PG_W | Page within the block (0 or 1) |
| rd_col | output | COL_W | Column of the request (marker column) |
| rd_data | input | DATA_W | Byte returned by the access layer |
| rd_valid | input | 1 | `rd_data` is valid for the current request |
| mark_req | input | 1 | Flag a block as bad |
| mark_block | input | BLK_W | Block to flag |
| lk_req | input | 1 | Lookup request |
| lk_block | input | BLK_W | Block to look up |
| lk_ack | output | 1 | Lookup answer valid |
| lk_bad | output | 1 | Looked-up block is flagged |
| lk_unknown | output | 1 | Scan not finished when the lookup was made |
| busy | output | 1 | Scan in progress |
| done | output | 1 | Scan complete |
| bad_count | output | CNT_W | Number of flagged blocks (0 while busy) |

## Verification
The bench builds the engine with 32 blocks of 16 pages, marker column 517 and page-1 skipping enabled. The short array lets two full scans, the last-block turn to `done` and a complete per-block lookup sweep fit in a few hundred cycles. It makes the first and final blocks bad in different pages. It varies the access layer's reply latency from zero to two idle cycles, so the held-address rule is exercised. It swaps the marker pattern between scans, so a block that was bad before the restart must read good afterwards.

// File: rtl/nand_bbscan_pkg.sv
package nand_bbscan_pkg;

   typedef enum logic [1:0] {
      ST_PG0  = 2'd0,
      ST_PG1  = 2'd1,
      ST_DONE = 2'd2
   } scan_st_e;

endpackage

// File: rtl/bbscan_walker.sv
module bbscan_walker
   import nand_bbscan_pkg::*;
#(
   parameter int NUM_BLOCKS      = 512,
   parameter int PAGES_PER_BLOCK = 16,
   parameter int PAGE_BYTES      = 528,
   parameter int MARK_COL        = 517,
   parameter int DATA_W          = 8,
   parameter logic [DATA_W-1:0] GOOD_BYTE = '1,
   parameter bit EARLY_SKIP      = 1'b1,
   localparam int BLK_W = $clog2(NUM_BLOCKS),
   localparam int PG_W  = $clog2(PAGES_PER_BLOCK),
   localparam int COL_W = $clog2(PAGE_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              rd_req,
   output logic [BLK_W-1:0]  rd_block,
   output logic [PG_W-1:0]   rd_page,
   output logic [COL_W-1:0]  rd_col,
   input  logic [DATA_W-1:0] rd_data,
   input  logic              rd_valid,
   output logic              hit_set,
   output logic [BLK_W-1:0]  hit_block,
   output logic              scan_done
);

   localparam logic [BLK_W-1:0] LAST_BLK = BLK_W'(NUM_BLOCKS - 1);

   scan_st_e           st_q;
   logic [BLK_W-1:0]   blk_q;
   logic               take;
   logic               byte_bad;
   logic               skip_pg1;
   logic               last_blk;

   assign take     = rd_req & rd_valid;
   assign byte_bad = (rd_data != GOOD_BYTE);
   assign last_blk = (blk_q == LAST_BLK);

   // variant: a marked first page may end the block early, or both pages are always read
   generate
      if (EARLY_SKIP) begin : g_skip
         assign skip_pg1 = byte_bad;
      end else begin : g_both
         assign skip_pg1 = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_PG0;
         blk_q <= '0;
      end else if (start) begin
         st_q  <= ST_PG0;
         blk_q <= '0;
      end else if (take) begin
         if (st_q == ST_PG0 && !skip_pg1) begin
            st_q <= ST_PG1;
         end else if (last_blk) begin
            st_q <= ST_DONE;
         end else begin
            st_q  <= ST_PG0;
            blk_q <= blk_q + 1'b1;
         end
      end
   end

   assign rd_req    = (st_q != ST_DONE);
   assign rd_block  = blk_q;
   assign rd_page   = (st_q == ST_PG1) ? PG_W'(1) : '0;
   assign rd_col    = COL_W'(MARK_COL);
   assign hit_set   = take & byte_bad & ~start;
   assign hit_block = blk_q;
   assign scan_done = (st_q == ST_DONE);

endmodule

// File: rtl/bbscan_map.sv
module bbscan_map #(
   parameter int NUM_BLOCKS = 512,
   localparam int BLK_W = $clog2(NUM_BLOCKS),
   localparam int CNT_W = $clog2(NUM_BLOCKS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             scan_set,
   input  logic [BLK_W-1:0] scan_blk,
   input  logic             ext_set,
   input  logic [BLK_W-1:0] ext_blk,
   input  logic             known,
   input  logic             lk_req,
   input  logic [BLK_W-1:0] lk_block,
   output logic             lk_ack,
   output logic             lk_bad,
   output logic             lk_unknown,
   output logic [CNT_W-1:0] count
);

   logic [NUM_BLOCKS-1:0] map_q;
   logic                  new_scan;
   logic                  new_ext;

   assign new_scan = scan_set & ~map_q[scan_blk];
   assign new_ext  = ext_set & ~map_q[ext_blk] & ~(scan_set && scan_blk == ext_blk);

   for (genvar i = 0; i < NUM_BLOCKS; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            map_q[i] <= 1'b0;
         end else if (clr) begin
            map_q[i] <= 1'b0;
         end else if ((scan_set && scan_blk == BLK_W'(i)) ||
                      (ext_set && ext_blk == BLK_W'(i))) begin
            map_q[i] <= 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else if (clr) begin
         count <= '0;
      end else begin
         count <= count + CNT_W'(new_scan) + CNT_W'(new_ext);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lk_ack     <= 1'b0;
         lk_bad     <= 1'b0;
         lk_unknown <= 1'b0;
      end else begin
         lk_ack     <= lk_req;
         lk_bad     <= lk_req & known & map_q[lk_block];
         lk_unknown <= lk_req & ~known;
      end
   end

endmodule

// File: rtl/nand_bbscan.sv
module nand_bbscan #(
   parameter int NUM_BLOCKS      = 512,
   parameter int PAGES_PER_BLOCK = 16,
   parameter int PAGE_BYTES      = 528,
   parameter int MARK_COL        = 517,
   parameter int DATA_W          = 8,
   parameter logic [DATA_W-1:0] GOOD_BYTE = '1,
   parameter bit EARLY_SKIP      = 1'b1,
   localparam int BLK_W = $clog2(NUM_BLOCKS),
   localparam int PG_W  = $clog2(PAGES_PER_BLOCK),
   localparam int COL_W = $clog2(PAGE_BYTES),
   localparam int CNT_W = $clog2(NUM_BLOCKS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              rd_req,
   output logic [BLK_W-1:0]  rd_block,
   output logic [PG_W-1:0]   rd_page,
   output logic [COL_W-1:0]  rd_col,
   input  logic [DATA_W-1:0] rd_data,
   input  logic              rd_valid,
   input  logic              mark_req,
   input  logic [BLK_W-1:0]  mark_block,
   input  logic              lk_req,
   input  logic [BLK_W-1:0]  lk_block,
   output logic              lk_ack,
   output logic              lk_bad,
   output logic              lk_unknown,
   output logic              busy,
   output logic              done,
   output logic [CNT_W-1:0]  bad_count
);

   generate
      if (NUM_BLOCKS < 2 || (NUM_BLOCKS & (NUM_BLOCKS - 1)) != 0) begin : g_err_blocks
         $error("NUM_BLOCKS must be a power of two of at least 2");
      end
      if (PAGES_PER_BLOCK < 2 || (PAGES_PER_BLOCK & (PAGES_PER_BLOCK - 1)) != 0) begin : g_err_pages
         $error("PAGES_PER_BLOCK must be a power of two of at least 2");
      end
      if (MARK_COL < 0 || MARK_COL >= PAGE_BYTES) begin : g_err_col
         $error("MARK_COL must lie inside the page");
      end
      if (DATA_W < 1) begin : g_err_data
         $error("DATA_W must be positive");
      end
   endgenerate

   logic             hit_set;
   logic [BLK_W-1:0] hit_block;
   logic             scan_done;
   logic [CNT_W-1:0] count;

   bbscan_walker #(
      .NUM_BLOCKS      (NUM_BLOCKS),
      .PAGES_PER_BLOCK (PAGES_PER_BLOCK),
      .PAGE_BYTES      (PAGE_BYTES),
      .MARK_COL        (MARK_COL),
      .DATA_W          (DATA_W),
      .GOOD_BYTE       (GOOD_BYTE),
      .EARLY_SKIP      (EARLY_SKIP)
   ) u_walk (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .rd_req    (rd_req),
      .rd_block  (rd_block),
      .rd_page   (rd_page),
      .rd_col    (rd_col),
      .rd_data   (rd_data),
      .rd_valid  (rd_valid),
      .hit_set   (hit_set),
      .hit_block (hit_block),
      .scan_done (scan_done)
   );

   bbscan_map #(
      .NUM_BLOCKS (NUM_BLOCKS)
   ) u_map (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (start),
      .scan_set   (hit_set),
      .scan_blk   (hit_block),
      .ext_set    (mark_req),
      .ext_blk    (mark_block),
      .known      (scan_done),
      .lk_req     (lk_req),
      .lk_block   (lk_block),
      .lk_ack     (lk_ack),
      .lk_bad     (lk_bad),
      .lk_unknown (lk_unknown),
      .count      (count)
   );

   assign done      = scan_done;
   assign busy      = ~scan_done;
   assign bad_count = scan_done ? count : '0;

endmodule

// File: rtl/nand_bbscan_chk.sv
module nand_bbscan_chk #(
   parameter int NUM_BLOCKS      = 512,
   parameter int PAGES_PER_BLOCK = 16,
   parameter int PAGE_BYTES      = 528,
   parameter int MARK_COL        = 517,
   parameter int DATA_W          = 8,
   parameter logic [DATA_W-1:0] GOOD_BYTE = '1,
   parameter bit EARLY_SKIP      = 1'b1,
   localparam int BLK_W = $clog2(NUM_BLOCKS),
   localparam int PG_W  = $clog2(PAGES_PER_BLOCK),
   localparam int COL_W = $clog2(PAGE_BYTES),
   localparam int CNT_W = $clog2(NUM_BLOCKS + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              rd_req,
   input logic [BLK_W-1:0]  rd_block,
   input logic [PG_W-1:0]   rd_page,
   input logic [COL_W-1:0]  rd_col,
   input logic [DATA_W-1:0] rd_data,
   input logic              rd_valid,
   input logic              lk_req,
   input logic              lk_ack,
   input logic              lk_unknown,
   input logic              lk_bad,
   input logic              done,
   input logic [CNT_W-1:0]  bad_count
);

   localparam logic [BLK_W-1:0] LAST_BLK = BLK_W'(NUM_BLOCKS - 1);

   // R2: marker column and first two pages only
   a_r2_marker_addr: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |-> (rd_col == COL_W'(MARK_COL) && rd_page < PG_W'(2)));

   // R2: address held while waiting for the byte
   a_r2_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !rd_valid && !start) |=> ($stable(rd_block) && $stable(rd_page) && rd_req));

   // R3: marked first page moves on to the next block
   a_r3_skip_second: assert property (@(posedge clk) disable iff (!rst_n)
      (EARLY_SKIP && rd_req && rd_valid && !start && rd_page == '0 &&
       rd_data != GOOD_BYTE && rd_block != LAST_BLK)
      |=> (rd_page == '0 && rd_block == $past(rd_block) + 1'b1));

   // R4: second page moves on to the next block
   a_r4_next_block: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && rd_valid && !start && rd_page == PG_W'(1) && rd_block != LAST_BLK)
      |=> (rd_page == '0 && rd_block == $past(rd_block) + 1'b1));

   // R6: restart from the first block
   a_r6_restart: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (rd_req && rd_block == '0 && rd_page == '0 && !done && bad_count == '0));

   // R8: early lookups come back unknown
   a_r8_unknown: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_req && !done) |=> (lk_ack && lk_unknown && !lk_bad));

   // R9: count never drops while the map stays valid
   a_r9_count_monotone: assert property (@(posedge clk) disable iff (!rst_n)
      (done && $past(done) && !$past(start)) |-> (bad_count >= $past(bad_count)));

endmodule

bind nand_bbscan nand_bbscan_chk #(
   .NUM_BLOCKS      (NUM_BLOCKS),
   .PAGES_PER_BLOCK (PAGES_PER_BLOCK),
   .PAGE_BYTES      (PAGE_BYTES),
   .MARK_COL        (MARK_COL),
   .DATA_W          (DATA_W),
   .GOOD_BYTE       (GOOD_BYTE),
   .EARLY_SKIP      (EARLY_SKIP)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .rd_req     (rd_req),
   .rd_block   (rd_block),
   .rd_page    (rd_page),
   .rd_col     (rd_col),
   .rd_data    (rd_data),
   .rd_valid   (rd_valid),
   .lk_req     (lk_req),
   .lk_ack     (lk_ack),
   .lk_unknown (lk_unknown),
   .lk_bad     (lk_bad),
   .done       (done),
   .bad_count  (bad_count)
);

// File: tb/sim_nand_bbscan.sv
`timescale 1ns/100ps
module sim_nand_bbscan;

   localparam int N     = 32;
   localparam int PGS   = 16;
   localparam int COL   = 517;
   localparam int BLK_W = $clog2(N);
   localparam int PG_W  = $clog2(PGS);
   localparam int COL_W = $clog2(528);
   localparam int CNT_W = $clog2(N + 1);

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start = 1'b0;
   logic             rd_req;
   logic [BLK_W-1:0] rd_block;
   logic [PG_W-1:0]  rd_page;
   logic [COL_W-1:0] rd_col;
   logic [7:0]       rd_data = 8'h00;
   logic             rd_valid = 1'b0;
   logic             mark_req = 1'b0;
   logic [BLK_W-1:0] mark_block = '0;
   logic             lk_req = 1'b0;
   logic [BLK_W-1:0] lk_block = '0;
   logic             lk_ack, lk_bad, lk_unknown, busy, done;
   logic [CNT_W-1:0] bad_count;

   int compared = 0;
   int mismatched = 0;
   int cycles = 0;
   int pat = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   nand_bbscan #(
      .NUM_BLOCKS(N), .PAGES_PER_BLOCK(PGS), .PAGE_BYTES(528),
      .MARK_COL(COL), .DATA_W(8), .GOOD_BYTE(8'hFF), .EARLY_SKIP(1'b1)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .start(start),
      .rd_req(rd_req), .rd_block(rd_block), .rd_page(rd_page), .rd_col(rd_col),
      .rd_data(rd_data), .rd_valid(rd_valid),
      .mark_req(mark_req), .mark_block(mark_block),
      .lk_req(lk_req), .lk_block(lk_block),
      .lk_ack(lk_ack), .lk_bad(lk_bad), .lk_unknown(lk_unknown),
      .busy(busy), .done(done), .bad_count(bad_count)
   );

   task automatic chk(input string tag, input int act, input int exp);
      compared++;
      if (act != exp) begin
         mismatched++;
         $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cycles);
      end
   endtask

   // flash content: marker byte per block, page and pattern
   function automatic logic [7:0] flash_byte(int b, int p, int c, int pt);
      if (c != COL || p > 1) return 8'h5A;
      if (pt == 0) begin
         if (p == 0 && b == 0) return 8'h7F;
         if (p == 0 && b % 5 == 3) return 8'h00;
         if (p == 1 && (b % 7 == 2 || b == N - 1)) return 8'hFE;
      end else begin
         if (p == 0 && b % 6 == 1) return 8'h00;
      end
      return 8'hFF;
   endfunction

   function automatic int expected_bad(int pt);
      int n = 0;
      for (int b = 0; b < N; b++)
         if (flash_byte(b, 0, COL, pt) != 8'hFF || flash_byte(b, 1, COL, pt) != 8'hFF) n++;
      return n;
   endfunction

   // access layer: replies after 0..2 idle cycles
   int lat_seq = 0;
   always begin
      int wait_n;
      @(posedge clk); #1;
      if (rd_valid) begin
         rd_valid = 1'b0;
         rd_data  = 8'h00;
      end else if (rd_req && rst_n) begin
         wait_n  = lat_seq % 3;
         lat_seq = lat_seq + 1;
         while (wait_n > 0 && rd_req) begin
            @(posedge clk); #1;
            wait_n--;
         end
         if (rd_req) begin
            rd_data  = flash_byte(int'(rd_block), int'(rd_page), int'(rd_col), pat);
            rd_valid = 1'b1;
         end
      end
   end

   // behavioural reference model
   bit m_bits [N];
   int m_blk = 0, m_pg = 0, m_cnt = 0;
   bit m_done = 0, e_ack = 0, e_bad = 0, e_unk = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_blk = 0; m_pg = 0; m_cnt = 0; m_done = 0;
         e_ack = 0; e_bad = 0; e_unk = 0;
         foreach (m_bits[i]) m_bits[i] = 0;
      end else begin
         e_ack = lk_req;
         e_unk = lk_req && !m_done;
         e_bad = lk_req && m_done && m_bits[lk_block];
         if (start) begin
            foreach (m_bits[i]) m_bits[i] = 0;
            m_cnt = 0; m_blk = 0; m_pg = 0; m_done = 0;
         end else begin
            if (mark_req && !m_bits[mark_block]) begin
               m_bits[mark_block] = 1; m_cnt++;
            end
            if (!m_done && rd_valid) begin
               if (rd_data != 8'hFF && !m_bits[m_blk]) begin
                  m_bits[m_blk] = 1; m_cnt++;
               end
               if (m_pg == 0 && rd_data == 8'hFF) m_pg = 1;
               else begin
                  m_pg = 0;
                  if (m_blk == N - 1) m_done = 1;
                  else m_blk++;
               end
            end
         end
      end
   end

   // per-clock comparison, sampled mid-cycle
   bit seen_reset = 0;
   always @(negedge clk) begin
      cycles++;
      if (!rst_n) seen_reset = 1;
      if (rst_n && seen_reset && !finished) begin
         chk("R4 rd_req", rd_req, !m_done);
         chk("R4 done", done, m_done);
         chk("R8 busy", busy, !m_done);
         chk("R5 bad_count", bad_count, m_done ? m_cnt : 0);
         if (!m_done) begin
            chk("R3 rd_block", rd_block, m_blk);
            chk("R2 rd_page", rd_page, m_pg);
            chk("R2 rd_col", rd_col, COL);
         end
         chk("R7 lk_ack", lk_ack, e_ack);
         chk("R7 lk_bad", lk_bad, e_bad);
         chk("R8 lk_unknown", lk_unknown, e_unk);
      end
   end

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic wait_done();
      while (!m_done) step();
   endtask

   task automatic lookup_all();
      for (int b = 0; b < N; b++) begin
         lk_req = 1'b1; lk_block = BLK_W'(b);
         step();
      end
      lk_req = 1'b0;
      step();
   endtask

   task automatic summary();
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   endtask

   initial begin
      while (cycles < 100000) @(negedge clk);
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual %0d expected <100000 cycles", cycles);
      summary();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1: state right after reset
      chk("R1 rd_req", rd_req, 1);
      chk("R1 rd_block", rd_block, 0);
      chk("R1 rd_page", rd_page, 0);
      chk("R1 rd_col", rd_col, COL);
      chk("R1 busy", busy, 1);
      chk("R1 bad_count", bad_count, 0);

      // R9: mark a good block during the scan, R8 lookup during scan
      step();
      mark_req = 1'b1; mark_block = BLK_W'(1);
      lk_req = 1'b1; lk_block = BLK_W'(3);
      step();
      mark_req = 1'b0; lk_req = 1'b0;
      @(negedge clk);
      chk("R8 lk_unknown mid-scan", lk_unknown, 1);

      wait_done();
      @(negedge clk);
      chk("R3 R5 count after scan", bad_count, expected_bad(0) + 1);
      step();
      lookup_all();

      // R9: mark good block 4 then already-bad block 3
      mark_req = 1'b1; mark_block = BLK_W'(4);
      step();
      mark_block = BLK_W'(3);
      step();
      mark_req = 1'b0;
      @(negedge clk);
      chk("R9 count after marks", bad_count, expected_bad(0) + 2);
      step();
      lk_req = 1'b1; lk_block = BLK_W'(4);
      step();
      lk_req = 1'b0;
      @(negedge clk);
      chk("R9 marked block reads bad", lk_bad, 1);

      // R6: restart with a new pattern, mark in the same cycle is dropped
      step();
      pat = 1;
      start = 1'b1; mark_req = 1'b1; mark_block = BLK_W'(5);
      step();
      start = 1'b0; mark_req = 1'b0;
      @(negedge clk);
      chk("R6 restart block", rd_block, 0);
      chk("R6 restart done", done, 0);
      chk("R6 restart count", bad_count, 0);
      wait_done();
      @(negedge clk);
      chk("R6 R9 count after rescan", bad_count, expected_bad(1));
      step();
      lk_req = 1'b1; lk_block = BLK_W'(3);
      step();
      lk_req = 1'b0;
      @(negedge clk);
      chk("R6 old flag cleared", lk_bad, 0);
      step();
      lookup_all();
      repeat (3) step();
      summary();
   end

endmodule